// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst memory. It captures an external address when either of two active-low address strobes begins a cycle. One strobe is meant for a processor and the other for a memory controller. The chip enables qualify each start. Afterwards the block produces the remaining addresses of a four-beat burst by itself, one step for each clock edge on which the advance input is held low.

A start from the processor strobe needs the master enable. A start from the controller strobe is taken only when the processor strobe is high on the same edge. The two low address bits count through the burst and the upper bits hold their latched value. The counting order is either interleaved (the start offset XOR a beat count) or linear (the start offset plus the beat count, modulo four). The order pin is captured while reset is held and is then frozen.

Top module: `bsram_addr_seq`

## Requirements
- R1: While reset is held and on the first edge after it, `selected` is 0, `start_pulse` is 0 and `cur_addr` is 0.
- R2: An edge with `pstrobe_n`=0, `en_main_n`=0, `en_hi`=1 and `en_lo_n`=0 starts a cycle, whatever the value of `cstrobe_n`. After that edge `cur_addr` equals the sampled `ext_addr`, `start_pulse` is 1 for one cycle and `selected` is 1.
- R3: An edge with `pstrobe_n`=0 and `en_main_n`=1 changes nothing. `cur_addr` and `selected` keep their values and `start_pulse` is 0.
- R4: An edge with `cstrobe_n`=0, `pstrobe_n`=1 and all three enables active starts a cycle in the same way as R2.
- R5: An edge with a recognised strobe deselects the block when any enable is inactive. A recognised strobe is `pstrobe_n`=0 with `en_main_n`=0, or `cstrobe_n`=0 with `pstrobe_n`=1. After such an edge `selected` is 0, `start_pulse` is 0 and `cur_addr` is held.
- R6: `cstrobe_n`=0 has no effect on an edge where `pstrobe_n`=0.
- R7: When selected, an edge with both strobes high and `adv_n`=0 moves `cur_addr` to the next burst address. The same edge with `adv_n`=1 holds `cur_addr`.
- R8: `adv_n` is ignored on an edge where `pstrobe_n` is 0.
- R9: With `order_sel`=1 during reset, beat k (k = 0..3) has low bits equal to the start offset XOR k.
- R10: With `order_sel`=0 during reset, beat k has low bits equal to (start offset + k) mod 4. No carry reaches the upper address bits.
- R11: After four beats the low bits wrap back to the start offset.
- R12: A change of `order_sel` after reset does not change the burst order.
- R13: While `selected` is 0, `adv_n`=0 does not change `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; `order_sel` is captured while it is low |
| pstrobe_n | input | 1 | Processor address strobe, active low |
| cstrobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_main_n | input | 1 | Master chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External address |
| cur_addr | output | ADDR_W | Current internal address |
| start_pulse | output | 1 | High for one cycle after a cycle start |
| selected | output | 1 | Block holds an active cycle |

## Verification
Two kinds of event can meet on one edge: a strobe and a burst advance, or both strobes together. The bench drives `adv_n` low on edges where the processor strobe is low. It does this once with the start allowed and once with it blocked by the master enable. A correct design reloads the address in the first case and holds it in the second. It never advances in either case. The bench also asserts both strobes together, with the master enable active and with it inactive. It checks that the controller strobe neither starts nor deselects a cycle on those edges.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [1:0] {
      ORD_PIN        = 2'd0,
      ORD_LINEAR     = 2'd1,
      ORD_INTERLEAVE = 2'd2
   } order_cfg_e;
endpackage

// File: rtl/bsq_start_decode.sv
// Decodes strobes and enables into start, deselect and advance-eligible events.
module bsq_start_decode (
   input  logic pstrobe_n,
   input  logic cstrobe_n,
   input  logic en_main_n,
   input  logic en_hi,
   input  logic en_lo_n,
   output logic start_ev,
   output logic desel_ev,
   output logic quiet
);
   logic all_on, p_seen, c_seen;

   always_comb begin
      all_on   = !en_main_n && en_hi && !en_lo_n;
      // master enable gates the processor strobe outright
      p_seen   = !pstrobe_n && !en_main_n;
      // controller strobe only counts while the processor strobe is idle
      c_seen   = !cstrobe_n && pstrobe_n;
      start_ev = (p_seen || c_seen) && all_on;
      desel_ev = (p_seen || c_seen) && !all_on;
      quiet    = pstrobe_n && cstrobe_n;
   end
endmodule

// File: rtl/bsq_beat_ctr.sv
// Beat counter: cleared on load, stepped on advance, wraps naturally.
module bsq_beat_ctr #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   output logic [BURST_W-1:0] beat
);
   always_ff @(posedge clk) begin
      if (!rst_n)     beat <= '0;
      else if (load)  beat <= '0;
      else if (step)  beat <= beat + 1'b1;
   end
endmodule

// File: rtl/bsq_offset_gen.sv
// Forms the in-burst offset from the start offset and the beat count.
module bsq_offset_gen #(
   parameter int                  BURST_W   = 2,
   parameter bsq_pkg::order_cfg_e ORDER_CFG = bsq_pkg::ORD_PIN
) (
   input  logic [BURST_W-1:0] start_off,
   input  logic [BURST_W-1:0] beat,
   input  logic               interleave,
   output logic [BURST_W-1:0] off
);
   logic [BURST_W-1:0] lin_off, ilv_off;

   always_comb begin
      lin_off = start_off + beat;
      ilv_off = start_off ^ beat;
   end

   generate
      if (ORDER_CFG == bsq_pkg::ORD_LINEAR) begin : g_lin
         assign off = lin_off;
      end else if (ORDER_CFG == bsq_pkg::ORD_INTERLEAVE) begin : g_ilv
         assign off = ilv_off;
      end else begin : g_pin
         assign off = interleave ? ilv_off : lin_off;
      end
   endgenerate
endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq #(
   parameter int                  ADDR_W    = 19,
   parameter int                  BURST_W   = 2,
   parameter bsq_pkg::order_cfg_e ORDER_CFG = bsq_pkg::ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pstrobe_n,
   input  logic              cstrobe_n,
   input  logic              adv_n,
   input  logic              en_main_n,
   input  logic              en_hi,
   input  logic              en_lo_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              start_pulse,
   output logic              selected
);
   localparam int HI_W = ADDR_W - BURST_W;

   generate
      if (BURST_W < 1 || BURST_W > 4) begin : g_bad_burst
         $error("BURST_W must lie in 1..4");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed BURST_W");
      end
   endgenerate

   logic               start_ev, desel_ev, quiet, step;
   logic [ADDR_W-1:0]  base_q;
   logic               sel_q, pulse_q, order_q;
   logic [BURST_W-1:0] beat, off;

   bsq_start_decode u_dec (
      .pstrobe_n (pstrobe_n),
      .cstrobe_n (cstrobe_n),
      .en_main_n (en_main_n),
      .en_hi     (en_hi),
      .en_lo_n   (en_lo_n),
      .start_ev  (start_ev),
      .desel_ev  (desel_ev),
      .quiet     (quiet)
   );

   assign step = quiet && !adv_n && sel_q;

   bsq_beat_ctr #(.BURST_W(BURST_W)) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_ev),
      .step  (step),
      .beat  (beat)
   );

   bsq_offset_gen #(.BURST_W(BURST_W), .ORDER_CFG(ORDER_CFG)) u_off (
      .start_off  (base_q[BURST_W-1:0]),
      .beat       (beat),
      .interleave (order_q),
      .off        (off)
   );

   // order pin is static: captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) order_q <= order_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         sel_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= start_ev;
         if (start_ev) begin
            base_q <= ext_addr;
            sel_q  <= 1'b1;
         end else if (desel_ev) begin
            sel_q  <= 1'b0;
         end
      end
   end

   assign cur_addr    = {base_q[ADDR_W-1:BURST_W], off};
   assign start_pulse = pulse_q;
   assign selected    = sel_q;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pstrobe_n,
   input logic              cstrobe_n,
   input logic              adv_n,
   input logic              en_main_n,
   input logic              en_hi,
   input logic              en_lo_n,
   input logic              order_sel,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              start_pulse,
   input logic              selected
);
   logic unused_ok;
   assign unused_ok = order_sel;

   a_r2_proc_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrobe_n && !en_main_n && en_hi && !en_lo_n)
      |=> (start_pulse && selected && cur_addr == $past(ext_addr)));

   a_r3_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrobe_n && en_main_n)
      |=> ($stable(cur_addr) && $stable(selected) && !start_pulse));

   a_r4_ctrl_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pstrobe_n && !cstrobe_n && !en_main_n && en_hi && !en_lo_n)
      |=> (start_pulse && selected && cur_addr == $past(ext_addr)));

   a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (((!pstrobe_n && !en_main_n) || (pstrobe_n && !cstrobe_n))
       && !(!en_main_n && en_hi && !en_lo_n))
      |=> (!selected && !start_pulse && $stable(cur_addr)));

   a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (selected && pstrobe_n && cstrobe_n && !adv_n)
      |=> (cur_addr != $past(cur_addr) && !start_pulse
           && cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pstrobe_n && cstrobe_n && adv_n)
      |=> ($stable(cur_addr) && $stable(selected)));

   a_r13_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!selected && pstrobe_n && cstrobe_n)
      |=> ($stable(cur_addr) && !selected));
endmodule

bind bsram_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bsram_addr_seq_test.sv
module bsram_addr_seq_test;
   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pstrobe_n = 1'b1, cstrobe_n = 1'b1, adv_n = 1'b1;
   logic          en_main_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
   logic          order_sel = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] cur_addr;
   logic          start_pulse, selected;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bsram_addr_seq uut (
      .clk(clk), .rst_n(rst_n), .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n),
      .adv_n(adv_n), .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
      .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr),
      .start_pulse(start_pulse), .selected(selected)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      pstrobe_n = 1'b1; cstrobe_n = 1'b1; adv_n = 1'b1;
      en_main_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0;
   endtask

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input bit ilv);
      logic [1:0] o;
      o = ilv ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
      return {b[AW-1:2], o};
   endfunction

   task automatic do_reset(input bit ord);
      idle();
      order_sel = ord;
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic proc_start(input logic [AW-1:0] a);
      ext_addr = a; pstrobe_n = 1'b0;
      tick();
      idle();
   endtask

   // R1
   task automatic t_reset_state();
      chk("R1 sel", 32'(selected), 0);
      chk("R1 pulse", 32'(start_pulse), 0);
      chk("R1 addr", 32'(cur_addr), 0);
      tick();
      chk("R1 addr after edge", 32'(cur_addr), 0);
   endtask

   // R2 with controller strobe also low, R8 advance low on the same edge
   task automatic t_pstart();
      ext_addr = 19'h2A5C6; pstrobe_n = 1'b0; cstrobe_n = 1'b0; adv_n = 1'b0;
      tick();
      idle();
      chk("R2 addr", 32'(cur_addr), 32'h2A5C6);
      chk("R2 pulse", 32'(start_pulse), 1);
      chk("R2 sel", 32'(selected), 1);
      chk("R8 no advance on strobe edge", 32'(cur_addr), 32'h2A5C6);
      tick();
      chk("R2 pulse one cycle", 32'(start_pulse), 0);
   endtask

   // R3, R6, R8: blocked processor strobe, controller strobe and advance low
   task automatic t_master_block();
      ext_addr = 19'h11111; pstrobe_n = 1'b0; cstrobe_n = 1'b0; adv_n = 1'b0;
      en_main_n = 1'b1;
      tick();
      idle();
      chk("R3 addr held", 32'(cur_addr), 32'h2A5C6);
      chk("R3 sel held", 32'(selected), 1);
      chk("R6 no ctrl start", 32'(start_pulse), 0);
      chk("R8 adv ignored", 32'(cur_addr), 32'h2A5C6);
   endtask

   // R4: controller start with processor strobe high
   task automatic t_cstart();
      ext_addr = 19'h0F0F1; cstrobe_n = 1'b0;
      tick();
      idle();
      chk("R4 addr", 32'(cur_addr), 32'h0F0F1);
      chk("R4 pulse", 32'(start_pulse), 1);
      chk("R4 sel", 32'(selected), 1);
   endtask

   // R5 deselect, R13 advance ignored while deselected
   task automatic t_deselect();
      ext_addr = 19'h33333; cstrobe_n = 1'b0; en_main_n = 1'b1;
      tick();
      idle();
      chk("R5 sel cleared", 32'(selected), 0);
      chk("R5 no pulse", 32'(start_pulse), 0);
      chk("R5 addr held", 32'(cur_addr), 32'h0F0F1);
      adv_n = 1'b0;
      tick(); tick();
      idle();
      chk("R13 addr held", 32'(cur_addr), 32'h0F0F1);
      chk("R13 still idle", 32'(selected), 0);
      proc_start(19'h44444);
      ext_addr = 19'h55555; pstrobe_n = 1'b0; en_lo_n = 1'b1;
      tick();
      idle();
      chk("R5 proc deselect", 32'(selected), 0);
      chk("R5 proc addr held", 32'(cur_addr), 32'h44444);
   endtask

   // R7, R9, R11 on an interleaved burst, with a stall in the middle
   task automatic t_burst(input logic [AW-1:0] a, input bit ilv, input string tag);
      proc_start(a);
      chk({tag, " beat0"}, 32'(cur_addr), 32'(a));
      for (int k = 1; k <= 4; k++) begin
         adv_n = 1'b0;
         tick();
         adv_n = 1'b1;
         chk({tag, " beat"}, 32'(cur_addr), 32'(beat_addr(a, k % 4, ilv)));
         if (k == 2) begin
            tick();
            chk("R7 stall holds", 32'(cur_addr), 32'(beat_addr(a, 2, ilv)));
         end
      end
      chk("R11 wrap to start", 32'(cur_addr), 32'(a));
   endtask

   // R12: pin flip after reset does not change order
   task automatic t_order_static();
      order_sel = 1'b0;
      t_burst(19'h7FFF5, 1'b1, "R12 interleave kept");
      order_sel = 1'b1;
   endtask

   initial begin
      do_reset(1'b1);
      t_reset_state();
      t_pstart();
      t_master_block();
      t_cstart();
      t_deselect();
      t_burst(19'h12341, 1'b1, "R9 R7 interleave");
      t_burst(19'h00002, 1'b1, "R9 interleave");
      t_order_static();
      do_reset(1'b0);
      t_burst(19'h12343, 1'b0, "R10 linear");
      t_burst(19'h7FFFE, 1'b0, "R10 linear no carry");
      order_sel = 1'b1;
      t_burst(19'h00001, 1'b0, "R12 linear kept");
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule